// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank SDR SDRAM from power-on to a usable state by driving its command pins (clock enable, chip select, row strobe, column strobe, write enable, bank and address) through the mandatory start-up order. Once it sees a start pulse, it raises clock enable and holds the bus at NOP for a power-up wait. It then issues a precharge of all banks, a configurable number of auto-refresh commands, and a load of the mode register. After a final settle time it raises a done flag.

From that point a periodic timer emits a one-cycle refresh request. A downstream scheduler turns each request into an auto-refresh command. Every delay is counted in controller clock cycles, derived from a clock-frequency parameter. The mode word is built from separate burst-length and CAS-latency parameters, always with sequential bursts and single-location writes. The refresh reload value is computed from the refresh period, the row count and the clock, less a fixed 20-cycle margin.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held (synchronous, active low) and afterwards until a start pulse, the outputs are: clock enable low, chip select high, row, column and write strobes high, bank and address zero, done low, refresh request low.
- R2: A start pulse sampled in the idle state raises clock enable from the next cycle on. The bus then shows NOP (chip select low, the three strobes high) for POWERUP_US × CLK_MHZ cycles.
- R3: The cycle after the power-up wait carries a precharge-all command: chip select, row strobe and write enable low, column strobe high, with address bit 10 set.
- R4: Exactly NUM_AREF auto-refresh commands follow (chip select, row and column strobes low, write enable high). The first comes TRP cycles after the precharge, and each further one comes TRC cycles after the previous.
- R5: TRC cycles after the last auto-refresh, one load-mode command is issued (all four command lines low) with bank zero. Its address carries the mode word, whose fields are:
  - bits 2:0: burst-length code, 0 for 1, 1 for 2, 2 for 4 and 4 for 8;
  - bit 3: zero (sequential bursts);
  - bits 6:4: the CAS latency, 2 or 3;
  - bits 8:7: zero;
  - bit 9: set (single-location writes);
  - all other bits: zero.
- R6: Every other cycle from the start pulse on shows NOP, with clock enable high.
- R7: The done flag rises TMRD cycles after the load-mode cycle and stays high until reset.
- R8: The refresh request is a one-cycle pulse, first seen RELOAD cycles after done rises and then every RELOAD cycles. RELOAD = REFRESH_MS × 1000 × CLK_MHZ / ROWS − 20, which is 683 for 64 ms, 8192 rows and 90 MHz.
- R9: A start pulse has no effect while a sequence is running or after done.
- R10: A reset in mid-sequence returns the outputs to the R1 state, and a later start replays the full sequence from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for the initialization sequence |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/mode address bus |
| init_done_o | output | 1 | High once initialization has completed |
| refresh_req_o | output | 1 | One-cycle periodic refresh request |

## Verification
The bench takes the cycle after the start pulse is sampled as step zero. From there every command is due at a fixed offset:
- precharge at the power-up count;
- auto-refresh commands at TRP plus multiples of TRC;
- load-mode after the last refresh interval;
- done TMRD later;
- refresh requests at whole multiples of RELOAD after done.

Bench functions turn each step number into the expected command, address, done and request values. The bench compares all of them on the falling edge of every cycle, so a command placed one cycle early or late shows up at once. Start pulses at random steps, and a reset at a random step of the second run, test that the schedule is neither disturbed by stray starts nor left half-done by a reset.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encodings and mode-word builder for the
// SDRAM initialization sequencer. Commands are {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_AREF  = 4'b0001;
    localparam logic [3:0] CMD_LMR   = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PWRUP, ST_PRE, ST_PRE_W, ST_AREF, ST_AREF_W,
        ST_LMR, ST_LMR_W, ST_DONE
    } seq_state_t;

    // Build the load-mode word: burst code, sequential type, CAS, single writes.
    function automatic logic [15:0] mode_word(input int burst_len, input int cas_lat);
        logic [2:0] bl_code;
        case (burst_len)
            2:       bl_code = 3'd1;
            4:       bl_code = 3'd2;
            8:       bl_code = 3'd4;
            default: bl_code = 3'd0;
        endcase
        mode_word = {6'd0, 1'b1, 2'b00, 3'(cas_lat), 1'b0, bl_code};
    endfunction

endpackage

// File: rtl/sdram_wait_cnt.sv
// Module: loadable down counter that stops at zero; used for every
// inter-command delay of the sequencer. Assumes the loader issues a load
// only when it starts a new wait.
module sdram_wait_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Count down from the loaded value and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= load_val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // Once at zero with no load, the counter must stay at zero (no wrap).
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sdram_refresh_tmr.sv
// Module: periodic refresh timer. Held at its start value while disabled.
// Once enabled it pulses req_o for one cycle every RELOAD cycles, the first
// pulse RELOAD cycles after enable rises. Assumes RELOAD >= 2.
module sdram_refresh_tmr #(
    parameter int RELOAD = 683
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic req_o
);
    localparam int RW = $clog2(RELOAD + 1);
    localparam logic [RW-1:0] START = RW'(RELOAD - 1);

    logic [RW-1:0] cnt_q;
    logic          req_q;

    // Period counter: reload on expiry, hold at start while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)  cnt_q <= START;
        else if (cnt_q == '0) cnt_q <= START;
        else                  cnt_q <= cnt_q - 1'b1;
    end

    // Register the expiry as a one-cycle request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= en_i && (cnt_q == '0);
    end

    assign req_o = req_q;

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    assert_req_after_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> en_i);

endmodule

// File: rtl/sdram_pwrup_seq.sv
// Module: SDRAM power-up sequencer top. On start: clock enable, power-up
// wait, precharge all, NUM_AREF auto-refreshes, load mode, TMRD settle,
// then init_done and periodic refresh requests.
// Assumes TRP, TRC, TMRD >= 2, NUM_AREF >= 1, ADDR_W >= 11.
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ    = 90,
    parameter int POWERUP_US = 100000,
    parameter int REFRESH_MS = 64,
    parameter int ROWS       = 8192,
    parameter int NUM_AREF   = 8,
    parameter int BURST_LEN  = 1,
    parameter int CAS_LAT    = 2,
    parameter int TRP        = 2,
    parameter int TRC        = 7,
    parameter int TMRD       = 2,
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o,
    output logic              refresh_req_o
);
    localparam int PW_CYC = POWERUP_US * CLK_MHZ;
    localparam int RELOAD = (REFRESH_MS * 1000 * CLK_MHZ) / ROWS - 20;
    localparam int WAIT_W = $clog2(PW_CYC + TRP + TRC + TMRD + 1);
    localparam int AR_W   = $clog2(NUM_AREF + 1);
    localparam logic [15:0] MODE = mode_word(BURST_LEN, CAS_LAT);

    seq_state_t        state_q, state_d;
    logic [AR_W-1:0]   aref_left_q;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;
    logic              wait_zero;
    logic [3:0]        cmd;

    sdram_wait_cnt #(.W(WAIT_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .zero_o     (wait_zero)
    );

    sdram_refresh_tmr #(.RELOAD(RELOAD)) u_rfsh (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (state_q == ST_DONE),
        .req_o (refresh_req_o)
    );

    // Next-state and wait-load selection for the command sequence.
    always_comb begin
        state_d   = state_q;
        wait_load = 1'b0;
        wait_val  = '0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_PWRUP; wait_load = 1'b1; wait_val = WAIT_W'(PW_CYC - 1);
            end
            ST_PWRUP:  if (wait_zero) state_d = ST_PRE;
            ST_PRE: begin
                state_d = ST_PRE_W; wait_load = 1'b1; wait_val = WAIT_W'(TRP - 2);
            end
            ST_PRE_W:  if (wait_zero) state_d = ST_AREF;
            ST_AREF: begin
                state_d = ST_AREF_W; wait_load = 1'b1; wait_val = WAIT_W'(TRC - 2);
            end
            ST_AREF_W: if (wait_zero) state_d = (aref_left_q == '0) ? ST_LMR : ST_AREF;
            ST_LMR: begin
                state_d = ST_LMR_W; wait_load = 1'b1; wait_val = WAIT_W'(TMRD - 2);
            end
            ST_LMR_W:  if (wait_zero) state_d = ST_DONE;
            default:   state_d = state_q;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remaining auto-refresh commands of the init sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                                aref_left_q <= '0;
        else if (state_q == ST_IDLE && start_i)    aref_left_q <= AR_W'(NUM_AREF);
        else if (state_q == ST_AREF)               aref_left_q <= aref_left_q - 1'b1;
    end

    // Command and address decode from the current state.
    always_comb begin
        addr_o = '0;
        ba_o   = '0;
        case (state_q)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE:  begin cmd = CMD_PRE; addr_o = ADDR_W'(16'h0400); end
            ST_AREF: cmd = CMD_AREF;
            ST_LMR:  begin cmd = CMD_LMR; addr_o = ADDR_W'(MODE); end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
    assign cke_o       = (state_q != ST_IDLE);
    assign init_done_o = (state_q == ST_DONE);

    assert_cmd_with_cke_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |-> cke_o);
    assert_all_arefs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LMR) |-> (aref_left_q == '0));
    assert_pre_then_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |=> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

endmodule

// File: tb/sdram_pwrup_seq_tb.sv
module sdram_pwrup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ = 90, POWERUP_US = 1, REFRESH_MS = 64, ROWS = 8192;
    localparam int NUM_AREF = 3, BURST_LEN = 4, CAS_LAT = 3;
    localparam int TRP = 3, TRC = 4, TMRD = 2, ADDR_W = 13, BA_W = 2;

    localparam int PW     = POWERUP_US * CLK_MHZ;
    localparam int AREF0  = PW + TRP;
    localparam int LMR_T  = AREF0 + NUM_AREF * TRC;
    localparam int DONE_T = LMR_T + TMRD;
    localparam int RELOAD = 683;  // 64 ms * 90 MHz / 8192 rows - 20

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
    logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, init_done_o, refresh_req_o;
    logic [BA_W-1:0] ba_o;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .POWERUP_US(POWERUP_US), .REFRESH_MS(REFRESH_MS), .ROWS(ROWS),
        .NUM_AREF(NUM_AREF), .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT),
        .TRP(TRP), .TRC(TRC), .TMRD(TMRD), .ADDR_W(ADDR_W), .BA_W(BA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cke_o(cke_o), .cs_n_o(cs_n_o),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o),
        .addr_o(addr_o), .init_done_o(init_done_o), .refresh_req_o(refresh_req_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected mode word per R5, computed from the requirement text.
    function automatic int exp_mode();
        int code;
        code = (BURST_LEN == 8) ? 4 : (BURST_LEN == 4) ? 2 : (BURST_LEN == 2) ? 1 : 0;
        return code + (CAS_LAT * 16) + 512;
    endfunction

    // Expected {cs_n,ras_n,cas_n,we_n} at step t after start acceptance.
    function automatic int exp_cmd(input int t);
        if (t == PW) return 4'b0010;
        if (t == LMR_T) return 4'b0000;
        if (t >= AREF0 && t < LMR_T && ((t - AREF0) % TRC) == 0) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic string tag_of(input int t);
        if (t < PW) return "R2";
        if (t == PW) return "R3";
        if (t == LMR_T) return "R5";
        if (exp_cmd(t) == 4'b0001) return "R4";
        return "R6";
    endfunction

    function automatic bit exp_req(input int t);
        return (t > DONE_T) && (((t - DONE_T) % RELOAD) == 0);
    endfunction

    task automatic check_reset_state(input string req);
        chk(cke_o == 1'b0, req, "cke", cke_o, 0);
        chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b1111, req, "cmd",
            {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hF);
        chk(addr_o == '0 && ba_o == '0, req, "addr/ba", addr_o, 0);
        chk(init_done_o == 1'b0, req, "done", init_done_o, 0);
        chk(refresh_req_o == 1'b0, req, "refresh_req", refresh_req_o, 0);
    endtask

    // Run one sequence; reset_at >= 0 applies a reset at that step (R10).
    task automatic run_seq(input int reset_at);
        int total;
        int idle;
        total = DONE_T + 3 * RELOAD + 2;
        idle = $urandom_range(2, 12);
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            check_reset_state("R1");
        end
        start_i = 1'b1;
        for (int t = 0; t < total; t++) begin
            @(negedge clk);
            if (t == reset_at) begin
                rst_n = 1'b0; start_i = 1'b0;
                repeat (3) @(negedge clk);
                check_reset_state("R10");
                rst_n = 1'b1;
                break;
            end
            chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'(exp_cmd(t)), tag_of(t), "cmd",
                {cs_n_o, ras_n_o, cas_n_o, we_n_o}, exp_cmd(t));
            chk(cke_o == 1'b1, "R2", "cke", cke_o, 1);
            if (t == PW) chk(addr_o[10] == 1'b1, "R3", "addr bit10", addr_o, 32'h400);
            if (t == LMR_T) begin
                chk(int'(addr_o) == exp_mode(), "R5", "mode word", addr_o, exp_mode());
                chk(ba_o == '0, "R5", "bank", ba_o, 0);
            end
            chk(init_done_o == (t >= DONE_T), "R7", "done", init_done_o, int'(t >= DONE_T));
            chk(refresh_req_o == exp_req(t), "R8", "refresh_req", refresh_req_o, int'(exp_req(t)));
            // Random start pulses mid-sequence must be ignored (R9).
            start_i = ($urandom_range(0, 9) == 0);
        end
        start_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;
        run_seq(-1);
        // Directed R9: start after done changes nothing.
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(init_done_o == 1'b1, "R9", "done after late start", init_done_o, 1);
        chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R9", "cmd after late start",
            {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'h7);
        // R10: reset at a random step inside the sequence, then full replay.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_seq($urandom_range(PW + 1, LMR_T + 1));
        run_seq(-1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule